// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows a processor through its power-management states and decides, state by state, whether the secondary cache clock runs and whether snoops and interrupts are accepted. It runs on an always-on reference clock. Its inputs are the halt and stop-grant requests, an active-low sleep pin, a flag that says whether the bus clock is running, and two request strobes, one for snoops and one for interrupts. It reports a 3-bit state code and a set of gating flags decoded from that state.

The lowest state keeps processor context while the bus clock is stopped, and in that state the cache clock is off. When the bus clock returns, the block holds in that state for a fixed phase-locked-loop settling interval, counted in reference cycles, before it steps back to Sleep. The interrupt-controller clock may be stopped only in the two sleep states. Any snoop, interrupt or sleep-pin movement seen during the deep state is illegal traffic. It sets a flag that stays set until reset.

Top module: `pwr_state_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state code becomes 0 (Normal), the violation flag clears and the cache clock enable is high.
- R2: In Normal (0), a stop-grant request moves the block to Stop-Grant (2) on the next edge. This takes priority over a halt request, which otherwise moves it to AutoHALT (1). An interrupt request in AutoHALT returns it to Normal. Releasing the stop-grant request in Stop-Grant returns it to Normal.
- R3: A snoop request in AutoHALT or Stop-Grant moves the block to HALT/Grant Snoop (3). It stays there while the request is held, and returns to the state it came from when the request drops.
- R4: With the sleep pin low in Stop-Grant, the block enters Sleep (4). Raising the pin in Sleep returns it to Stop-Grant. A low sleep pin in Normal has no effect.
- R5: In Sleep, a stopped bus clock moves the block to Deep Sleep (5) on the next edge.
- R6: The block leaves Deep Sleep for Sleep only after the bus clock has been seen running for STAB_CYCLES consecutive edges. A stopped bus clock during that interval restarts the count.
- R7: The cache clock enable is low in Deep Sleep and high in every other state. It rises again only as the block enters Sleep.
- R8: Snoop-accept is high only in Normal and HALT/Grant Snoop. Interrupt-accept is low in Sleep and Deep Sleep and high in every other state.
- R9: The interrupt-clock-may-stop flag is high only in Sleep and Deep Sleep.
- R10: While in Deep Sleep, any of the following sets the violation flag at that edge: a snoop request, an interrupt request, or a change of the sleep pin level. The flag then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Halt request |
| stpgnt_req | input | 1 | Stop-grant request, held while granted |
| sleep_n | input | 1 | Sleep pin, active low |
| bclk_run | input | 1 | High while the bus clock is running |
| snoop_req | input | 1 | Snoop request, held until the snoop completes |
| intr_req | input | 1 | Interrupt request |
| state_code | output | 3 | Current state: 0 Normal, 1 AutoHALT, 2 Stop-Grant, 3 HALT/Grant Snoop, 4 Sleep, 5 Deep Sleep |
| cache_clk_en | output | 1 | Secondary cache clock enable |
| snoop_ack | output | 1 | Snoops are accepted |
| intr_ack | output | 1 | Interrupts are accepted |
| picclk_stop_ok | output | 1 | Interrupt-controller clock may be stopped |
| proto_viol | output | 1 | Sticky protocol-violation flag |

## Verification
Every output comes straight from registered state. A wrong transition therefore shows up on `state_code` and on the gating flags one edge after the input that caused it, and stays visible until the next transition.

A counter that is off by one cycle moves the return from Deep Sleep by exactly one edge. The same error shows as a cache clock that re-enables early or late. A violation monitor that misses an event, or that forgets its flag, shows on `proto_viol` at that same edge and on every edge after it.

// File: rtl/pwr_seq_pkg.sv
// Package: shared state encoding for the low-power sequencer.
// Assumes the 3-bit codes below are decoded by neighbouring logic,
// so the values are fixed and must not be renumbered.
package pwr_seq_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_NORM = 3'd0,
        ST_AHLT = 3'd1,
        ST_SGNT = 3'd2,
        ST_HGSN = 3'd3,
        ST_SLP  = 3'd4,
        ST_DSLP = 3'd5
    } pstate_t;

    // True in the two states where the processor ignores outside traffic.
    function automatic logic is_asleep(pstate_t s);
        return (s == ST_SLP) || (s == ST_DSLP);
    endfunction

endpackage

// File: rtl/pwr_stab_timer.sv
// Module: settling-interval counter for the clock-generator lock time.
// Counts consecutive cycles in which `run` is high. `done` pulses in the
// cycle that completes STAB_CYCLES of them. Dropping `run` clears the count.
// Assumes STAB_CYCLES >= 1.
module pwr_stab_timer #(
    parameter int STAB_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    logic [CW-1:0] cnt;

    // Terminal count is reached while the bus clock is still running.
    assign done = run && (cnt == LAST);

    // Advance while run is high, and restart on a gap or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwr_state_fsm.sv
// Module: power-state register and next-state logic.
// Remembers which quiescent state a snoop interrupted, so that it can
// return there. Assumes snoop_req is held high for the whole snoop.
module pwr_state_fsm
    import pwr_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    halt_req,
    input  logic    stpgnt_req,
    input  logic    sleep_n,
    input  logic    bclk_run,
    input  logic    snoop_req,
    input  logic    intr_req,
    input  logic    stab_done,
    output pstate_t cur
);
    pstate_t nxt;
    pstate_t ret_q;
    pstate_t ret_d;

    // Next state and snoop-return target, from the current state and inputs.
    always_comb begin
        nxt   = cur;
        ret_d = ret_q;
        case (cur)
            ST_NORM: begin
                if (stpgnt_req) begin
                    nxt = ST_SGNT;
                end else if (halt_req) begin
                    nxt = ST_AHLT;
                end
            end
            ST_AHLT: begin
                if (snoop_req) begin
                    nxt   = ST_HGSN;
                    ret_d = ST_AHLT;
                end else if (intr_req) begin
                    nxt = ST_NORM;
                end
            end
            ST_SGNT: begin
                if (snoop_req) begin
                    nxt   = ST_HGSN;
                    ret_d = ST_SGNT;
                end else if (!sleep_n) begin
                    nxt = ST_SLP;
                end else if (!stpgnt_req) begin
                    nxt = ST_NORM;
                end
            end
            ST_HGSN: begin
                if (!snoop_req) begin
                    nxt = ret_q;
                end
            end
            ST_SLP: begin
                if (!bclk_run) begin
                    nxt = ST_DSLP;
                end else if (sleep_n) begin
                    nxt = ST_SGNT;
                end
            end
            ST_DSLP: begin
                if (stab_done) begin
                    nxt = ST_SLP;
                end
            end
            default: nxt = ST_NORM;
        endcase
    end

    // State and return-target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= ST_NORM;
            ret_q <= ST_AHLT;
        end else begin
            cur   <= nxt;
            ret_q <= ret_d;
        end
    end

endmodule

// File: rtl/pwr_out_decode.sv
// Module: per-state gating flags.
// Purely combinational from the registered state, so every flag changes
// on the same edge as the state code.
module pwr_out_decode
    import pwr_seq_pkg::*;
(
    input  pwr_seq_pkg::pstate_t cur,
    output logic    cache_clk_en,
    output logic    snoop_ack,
    output logic    intr_ack,
    output logic    picclk_stop_ok
);
    // Decode the gating flags from the state.
    always_comb begin
        cache_clk_en   = (cur != ST_DSLP);
        snoop_ack      = (cur == ST_NORM) || (cur == ST_HGSN);
        intr_ack       = !is_asleep(cur);
        picclk_stop_ok = is_asleep(cur);
    end

endmodule

// File: rtl/pwr_viol_mon.sv
// Module: sticky monitor for illegal bus activity during Deep Sleep.
// Watches the snoop and interrupt requests and sleep-pin edges while
// in_dslp is high. Only a reset clears the flag.
module pwr_viol_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic in_dslp,
    input  logic snoop_req,
    input  logic intr_req,
    input  logic sleep_n,
    output logic viol
);
    logic sleep_q;
    logic event_seen;

    // Any request, or any change of the sleep pin level.
    assign event_seen = snoop_req || intr_req || (sleep_n != sleep_q);

    // Track the previous sleep-pin level and accumulate the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q <= 1'b1;
            viol    <= 1'b0;
        end else begin
            sleep_q <= sleep_n;
            viol    <= viol || (in_dslp && event_seen);
        end
    end

endmodule

// File: rtl/pwr_state_seq.sv
// Module: top of the low-power state sequencer.
// Ties together the state machine, the settling timer, the output decode
// and the violation monitor. STAB_CYCLES is the settling time in reference
// cycles. The default is 1 ms at 100 MHz.
module pwr_state_seq
    import pwr_seq_pkg::*;
#(
    parameter int STAB_CYCLES = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       stpgnt_req,
    input  logic       sleep_n,
    input  logic       bclk_run,
    input  logic       snoop_req,
    input  logic       intr_req,
    output logic [2:0] state_code,
    output logic       cache_clk_en,
    output logic       snoop_ack,
    output logic       intr_ack,
    output logic       picclk_stop_ok,
    output logic       proto_viol
);
    pstate_t cur;
    logic    in_dslp;
    logic    stab_done;

    assign in_dslp    = (cur == ST_DSLP);
    assign state_code = cur;

    pwr_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_dslp && bclk_run),
        .done  (stab_done)
    );

    pwr_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_req   (halt_req),
        .stpgnt_req (stpgnt_req),
        .sleep_n    (sleep_n),
        .bclk_run   (bclk_run),
        .snoop_req  (snoop_req),
        .intr_req   (intr_req),
        .stab_done  (stab_done),
        .cur        (cur)
    );

    pwr_out_decode u_dec (
        .cur            (cur),
        .cache_clk_en   (cache_clk_en),
        .snoop_ack      (snoop_ack),
        .intr_ack       (intr_ack),
        .picclk_stop_ok (picclk_stop_ok)
    );

    pwr_viol_mon u_viol (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_dslp   (in_dslp),
        .snoop_req (snoop_req),
        .intr_req  (intr_req),
        .sleep_n   (sleep_n),
        .viol      (proto_viol)
    );

endmodule

// File: rtl/pwr_state_seq_chk.sv
// Module: property checker for pwr_state_seq. It sees only the top-level
// ports and is attached to every instance by the bind statement at the
// end of this file.
module pwr_state_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_req,
    input logic       stpgnt_req,
    input logic       sleep_n,
    input logic       bclk_run,
    input logic       snoop_req,
    input logic       intr_req,
    input logic [2:0] state_code,
    input logic       cache_clk_en,
    input logic       snoop_ack,
    input logic       intr_ack,
    input logic       picclk_stop_ok,
    input logic       proto_viol
);
    // R2
    norm_to_sgnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd0 && stpgnt_req) |=> (state_code == 3'd2));

    // R3
    snoop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3 && !snoop_req) |=> (state_code == 3'd1 || state_code == 3'd2));

    // R5
    sleep_to_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd4 && !bclk_run) |=> (state_code == 3'd5));

    // R6
    deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5 && !bclk_run) |=> (state_code == 3'd5));

    // R7
    cache_off_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cache_clk_en) |-> ($past(state_code) == 3'd4 && state_code == 3'd5));

    // R7
    cache_on_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cache_clk_en) |-> (state_code == 3'd4));

    // R8
    asleep_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd4 || state_code == 3'd5) |-> (!snoop_ack && !intr_ack));

    // R9
    picclk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        picclk_stop_ok |-> (state_code == 3'd4 || state_code == 3'd5));

    // R10
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_viol |=> proto_viol);

    // R10
    viol_deep_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5 && (snoop_req || intr_req)) |=> proto_viol);

endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .halt_req       (halt_req),
    .stpgnt_req     (stpgnt_req),
    .sleep_n        (sleep_n),
    .bclk_run       (bclk_run),
    .snoop_req      (snoop_req),
    .intr_req       (intr_req),
    .state_code     (state_code),
    .cache_clk_en   (cache_clk_en),
    .snoop_ack      (snoop_ack),
    .intr_ack       (intr_ack),
    .picclk_stop_ok (picclk_stop_ok),
    .proto_viol     (proto_viol)
);

// File: tb/pwr_state_seq_test.sv
// Scoreboard bench. A driver task applies inputs on the falling edge and
// queues the expected state and flag. A monitor pops one entry per rising
// edge and compares it with the outputs.
module pwr_state_seq_test;
    localparam int STAB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0;
    logic       stpgnt_req = 1'b0;
    logic       sleep_n = 1'b1;
    logic       bclk_run = 1'b1;
    logic       snoop_req = 1'b0;
    logic       intr_req = 1'b0;
    logic [2:0] state_code;
    logic       cache_clk_en;
    logic       snoop_ack;
    logic       intr_ack;
    logic       picclk_stop_ok;
    logic       proto_viol;

    typedef struct {
        logic [2:0] st;
        logic       viol;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2 clk = ~clk;

    pwr_state_seq #(.STAB_CYCLES(STAB)) uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stpgnt_req(stpgnt_req),
        .sleep_n(sleep_n), .bclk_run(bclk_run), .snoop_req(snoop_req),
        .intr_req(intr_req), .state_code(state_code), .cache_clk_en(cache_clk_en),
        .snoop_ack(snoop_ack), .intr_ack(intr_ack), .picclk_stop_ok(picclk_stop_ok),
        .proto_viol(proto_viol)
    );

    // Apply one input vector and queue the result expected after the next edge.
    task automatic step(input logic h, input logic sg, input logic sl, input logic bk,
                        input logic sn, input logic it, input logic [2:0] st,
                        input logic v, input string tag);
        exp_t e;
        @(negedge clk);
        halt_req = h; stpgnt_req = sg; sleep_n = sl; bclk_run = bk;
        snoop_req = sn; intr_req = it;
        e.st = st; e.viol = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic miss(input string tag, input string what, input int act, input int expv);
        n_bad++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    endtask

    // Monitor: compare the outputs after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic asleep;
                e = exp_q.pop_front();
                asleep = (e.st == 3'd4) || (e.st == 3'd5);
                n_vec++;
                if (state_code !== e.st) miss(e.tag, "state", state_code, e.st);
                if (proto_viol !== e.viol) miss({e.tag, "/R10"}, "viol", proto_viol, e.viol);
                if (cache_clk_en !== (e.st != 3'd5))
                    miss({e.tag, "/R7"}, "cache_en", cache_clk_en, e.st != 3'd5);
                if (snoop_ack !== (e.st == 3'd0 || e.st == 3'd3))
                    miss({e.tag, "/R8"}, "snoop_ack", snoop_ack, e.st == 3'd0 || e.st == 3'd3);
                if (intr_ack !== !asleep) miss({e.tag, "/R8"}, "intr_ack", intr_ack, !asleep);
                if (picclk_stop_ok !== asleep)
                    miss({e.tag, "/R9"}, "picclk_stop", picclk_stop_ok, asleep);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        // R1 reset state
        step(0, 0, 1, 1, 0, 0, 3'd0, 0, "R1");
        step(0, 0, 1, 1, 0, 0, 3'd0, 0, "R1");
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 1, 1, 0, 0, 3'd0, 0, "R1");
        // R4 a low sleep pin in Normal is ignored
        step(0, 0, 0, 1, 0, 0, 3'd0, 0, "R4");
        step(0, 0, 1, 1, 0, 0, 3'd0, 0, "R4");
        // R2 stop-grant wins over halt; releasing it returns to Normal
        step(1, 1, 1, 1, 0, 0, 3'd2, 0, "R2");
        step(0, 0, 1, 1, 0, 0, 3'd0, 0, "R2");
        step(1, 0, 1, 1, 0, 0, 3'd1, 0, "R2");
        step(0, 0, 1, 1, 0, 0, 3'd1, 0, "R2");
        // R3 snoop from AutoHALT and back
        step(0, 0, 1, 1, 1, 0, 3'd3, 0, "R3");
        step(0, 0, 1, 1, 1, 0, 3'd3, 0, "R3");
        step(0, 0, 1, 1, 0, 0, 3'd1, 0, "R3");
        // R2 interrupt wakes AutoHALT
        step(0, 0, 1, 1, 0, 1, 3'd0, 0, "R2");
        step(0, 0, 1, 1, 0, 0, 3'd0, 0, "R2");
        // R3 snoop from Stop-Grant and back
        step(0, 1, 1, 1, 0, 0, 3'd2, 0, "R2");
        step(0, 1, 1, 1, 1, 0, 3'd3, 0, "R3");
        step(0, 1, 1, 1, 0, 0, 3'd2, 0, "R3");
        // R4 Sleep entry and exit
        step(0, 1, 0, 1, 0, 0, 3'd4, 0, "R4");
        step(0, 1, 1, 1, 0, 0, 3'd2, 0, "R4");
        step(0, 1, 0, 1, 0, 0, 3'd4, 0, "R4");
        // R5 bus clock stops
        step(0, 1, 0, 0, 0, 0, 3'd5, 0, "R5");
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, 3'd5, 0, "R6");
        // R6 interrupted settling restarts the count
        for (int i = 0; i < 5; i++) step(0, 1, 0, 1, 0, 0, 3'd5, 0, "R6");
        step(0, 1, 0, 0, 0, 0, 3'd5, 0, "R6");
        for (int i = 0; i < STAB - 1; i++) step(0, 1, 0, 1, 0, 0, 3'd5, 0, "R6");
        step(0, 1, 0, 1, 0, 0, 3'd4, 0, "R6");
        step(0, 1, 1, 1, 0, 0, 3'd2, 0, "R4");
        step(0, 0, 1, 1, 0, 0, 3'd0, 0, "R2");
        // R10 an interrupt in Deep Sleep sets the sticky flag
        step(0, 1, 1, 1, 0, 0, 3'd2, 0, "R2");
        step(0, 1, 0, 1, 0, 0, 3'd4, 0, "R4");
        step(0, 1, 0, 0, 0, 0, 3'd5, 0, "R5");
        step(0, 1, 0, 0, 0, 1, 3'd5, 1, "R10");
        step(0, 1, 0, 0, 0, 0, 3'd5, 1, "R10");
        for (int i = 0; i < STAB - 1; i++) step(0, 1, 0, 1, 0, 0, 3'd5, 1, "R6");
        step(0, 1, 0, 1, 0, 0, 3'd4, 1, "R6");
        step(0, 1, 1, 1, 0, 0, 3'd2, 1, "R10");
        step(0, 0, 1, 1, 0, 0, 3'd0, 1, "R10");
        // R1 reset clears the flag
        @(negedge clk); rst_n = 1'b0;
        step(0, 0, 1, 1, 0, 0, 3'd0, 0, "R1");
        @(negedge clk); rst_n = 1'b1;
        // R10 a sleep-pin edge in Deep Sleep
        step(0, 1, 1, 1, 0, 0, 3'd2, 0, "R2");
        step(0, 1, 0, 1, 0, 0, 3'd4, 0, "R4");
        step(0, 1, 0, 0, 0, 0, 3'd5, 0, "R5");
        step(0, 1, 1, 0, 0, 0, 3'd5, 1, "R10");
        step(0, 1, 1, 0, 0, 0, 3'd5, 1, "R10");
        // R10 a snoop in Deep Sleep, on a fresh flag
        @(negedge clk); rst_n = 1'b0;
        step(0, 0, 1, 1, 0, 0, 3'd0, 0, "R1");
        @(negedge clk); rst_n = 1'b1;
        step(0, 1, 1, 1, 0, 0, 3'd2, 0, "R2");
        step(0, 1, 0, 1, 0, 0, 3'd4, 0, "R4");
        step(0, 1, 0, 0, 0, 0, 3'd5, 0, "R5");
        step(0, 1, 0, 0, 1, 0, 3'd5, 1, "R10");
        step(0, 1, 0, 0, 0, 0, 3'd5, 1, "R10");
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule